// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor

This block is a 32-bit processor core that completes one instruction in every clock cycle. The program counter selects a word from an internal instruction store. A combinational decoder turns that word into steering signals for a register file, a sign-extender, an ALU, a PC+4 incrementer and a branch-target adder. Loads and stores go to a separate internal data store. The instruction set has five operations: register add and subtract, load of a signed constant, word load, word store, and branch when two registers are equal.

The core has no bus to the outside. While reset is held, a simple load port writes words into either store. Two peek ports read any register and any data word combinationally, so results can be inspected once a program has parked itself in a branch-to-self loop.

Top module: `cpu_single_cycle`

## Requirements
- R1: While `rst` is high on a rising edge, the PC becomes 0 and all 32 registers become 0. Neither store is cleared.
- R2: Opcode 0 (bits 31:26) with funct 32 (bits 5:0) writes rs+rt into rd. Funct 34 writes rs−rt into rd. Any other funct writes no register. The fields are rs at 25:21, rt at 20:16 and rd at 15:11.
- R3: Opcode 13 writes rs + sign-extended bits 15:0 into rt. With rs = 0 this loads a signed 16-bit constant.
- R4: Opcode 35 loads rt from the data word at byte address rs + sign-extended imm16. Opcode 43 stores rt there. The word index is address bits above bit 1, and only opcode 43 writes the data store.
- R5: Opcode 4 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. If not, the next PC is PC+4.
- R6: Register 0 always reads as zero, and writes to it are dropped.
- R7: An unknown opcode only advances the PC. Stores and branches write no register.
- R8: Each instruction other than a taken branch moves the PC forward by 4. The fetched word is the instruction-store entry at PC bits above bit 1.
- R9: On a rising edge, `load_we` writes `load_data` into the instruction store when `load_to_imem` is 1, and into the data store otherwise, at word index `load_addr`. The peek ports return register `peek_reg` and data word `peek_addr` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Preload write strobe |
| load_to_imem | input | 1 | 1 selects the instruction store, 0 the data store |
| load_addr | input | PADDR_W | Preload word index |
| load_data | input | 32 | Preload word |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_addr | input | PADDR_W | Data word index to observe |
| peek_mem_data | output | 32 | Value of the observed data word |
| pc_out | output | 32 | Current program counter |

## Verification
The core executes each instruction in a single cycle, so an internal error becomes visible after the instruction that exposes it. A wrong register value appears on the peek port once write-back has happened. A bad store shows up in the data word one edge later. A branch decision or target error moves `pc_out` at the very next edge and then sends the whole program down the wrong path. The checks therefore compare every register, every written data word and the final parked PC of each program. Those programs are directed corner cases plus random add/subtract/immediate/memory streams, and the expected values are computed by a behavioural model in the bench.

// File: rtl/scp_pkg.sv
package scp_pkg;
   localparam int XLEN = 32;

   localparam logic [5:0] OP_REG = 6'd0;
   localparam logic [5:0] OP_BEQ = 6'd4;
   localparam logic [5:0] OP_LDI = 6'd13;
   localparam logic [5:0] OP_LW  = 6'd35;
   localparam logic [5:0] OP_SW  = 6'd43;

   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;

   typedef enum logic [3:0] {
      ALU_ADD = 4'd2,
      ALU_SUB = 4'd6
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_is_rd;
      logic    b_is_imm;
      logic    mem_rd;
      logic    mem_we;
      logic    branch;
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
   import scp_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opcode)
         OP_REG: begin
            if (funct == FN_ADD) begin
               ctrl.reg_we    = 1'b1;
               ctrl.dst_is_rd = 1'b1;
            end else if (funct == FN_SUB) begin
               ctrl.reg_we    = 1'b1;
               ctrl.dst_is_rd = 1'b1;
               ctrl.alu_op    = ALU_SUB;
            end
         end
         OP_LDI: begin
            ctrl.reg_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
         end
         OP_LW: begin
            ctrl.reg_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
            ctrl.mem_rd   = 1'b1;
         end
         OP_SW: begin
            ctrl.mem_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
   parameter int W     = 32,
   parameter int NREG  = 32,
   parameter int AW    = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra_a,
   output logic [W-1:0]  rd_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rd_b,
   input  logic [AW-1:0] ra_c,
   output logic [W-1:0]  rd_c,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   if (NREG != (1 << AW)) begin : g_bad_depth
      $error("scp_regfile: NREG must equal 2**AW");
   end

   logic [NREG-1:0][W-1:0] bank;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign bank[g] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && wa == AW'(g))
               q <= wd;
         end
         assign bank[g] = q;
      end
   end

   assign rd_a = bank[ra_a];
   assign rd_b = bank[ra_b];
   assign rd_c = bank[ra_c];
endmodule

// File: rtl/scp_alu.sv
module scp_alu
   import scp_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         zero,
   output logic         carry
);
   logic [W:0] wide;

   always_comb begin
      unique case (op)
         ALU_ADD: wide = {1'b0, a} + {1'b0, b};
         ALU_SUB: wide = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
         default: wide = '0;
      endcase
   end

   assign y     = wide[W-1:0];
   assign carry = wide[W];
   assign zero  = (wide[W-1:0] == '0);
endmodule

// File: rtl/cpu_single_cycle.sv
module cpu_single_cycle
   import scp_pkg::*;
#(
   parameter int IMEM_WORDS     = 128,
   parameter int DMEM_WORDS     = 64,
   parameter int PADDR_W        = 16,
   parameter bit BRANCH_VIA_ALU = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_we,
   input  logic               load_to_imem,
   input  logic [PADDR_W-1:0] load_addr,
   input  logic [31:0]        load_data,
   input  logic [4:0]         peek_reg,
   output logic [31:0]        peek_reg_data,
   input  logic [PADDR_W-1:0] peek_addr,
   output logic [31:0]        peek_mem_data,
   output logic [31:0]        pc_out
);
   localparam int IA = $clog2(IMEM_WORDS);
   localparam int DA = $clog2(DMEM_WORDS);

   if (XLEN != 32) begin : g_bad_xlen
      $error("cpu_single_cycle: encoding assumes 32-bit words");
   end
   if (IMEM_WORDS != (1 << IA) || DMEM_WORDS != (1 << DA)) begin : g_bad_mem
      $error("cpu_single_cycle: store depths must be powers of two");
   end
   if (PADDR_W < IA || PADDR_W < DA) begin : g_bad_paddr
      $error("cpu_single_cycle: PADDR_W too narrow for a store");
   end
   if (IA + 2 > XLEN || DA + 2 > XLEN) begin : g_bad_span
      $error("cpu_single_cycle: store larger than the address space");
   end

   // program counter and fetch
   logic [31:0] pc_q, pc_next, pc_plus4, pc_branch;
   logic [31:0] imem [IMEM_WORDS];
   logic [31:0] instr;

   always_ff @(posedge clk) begin
      if (load_we && load_to_imem)
         imem[load_addr[IA-1:0]] <= load_data;
   end

   assign instr = imem[pc_q[IA+1:2]];

   // field split
   logic [5:0] opcode, funct;
   logic [4:0] rs, rt, rd;
   logic [31:0] imm_ext;

   assign opcode  = instr[31:26];
   assign rs      = instr[25:21];
   assign rt      = instr[20:16];
   assign rd      = instr[15:11];
   assign funct   = instr[5:0];
   assign imm_ext = {{16{instr[15]}}, instr[15:0]};

   // decode
   ctrl_t ctrl;
   scp_decode u_decode (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   // register file
   logic [31:0] rs_val, rt_val, wb_data;
   logic [4:0]  wb_addr;
   logic        rf_we;

   assign rf_we   = ctrl.reg_we;
   assign wb_addr = ctrl.dst_is_rd ? rd : rt;

   scp_regfile #(.W(32), .NREG(32), .AW(5)) u_regs (
      .clk  (clk),
      .rst  (rst),
      .ra_a (rs),
      .rd_a (rs_val),
      .ra_b (rt),
      .rd_b (rt_val),
      .ra_c (peek_reg),
      .rd_c (peek_reg_data),
      .we   (rf_we),
      .wa   (wb_addr),
      .wd   (wb_data)
   );

   // execute
   logic [31:0] alu_b, alu_y;
   logic        alu_zero, alu_carry;

   assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

   scp_alu #(.W(32)) u_alu (
      .op    (ctrl.alu_op),
      .a     (rs_val),
      .b     (alu_b),
      .y     (alu_y),
      .zero  (alu_zero),
      .carry (alu_carry)
   );

   // data store
   logic [31:0] dmem [DMEM_WORDS];
   logic [31:0] dmem_rdata;
   logic        dmem_we;

   assign dmem_we = ctrl.mem_we & ~rst;

   always_ff @(posedge clk) begin
      if (load_we && !load_to_imem)
         dmem[load_addr[DA-1:0]] <= load_data;
      else if (dmem_we)
         dmem[alu_y[DA+1:2]] <= rt_val;
   end

   assign dmem_rdata    = dmem[alu_y[DA+1:2]];
   assign peek_mem_data = dmem[peek_addr[DA-1:0]];
   assign wb_data       = ctrl.mem_rd ? dmem_rdata : alu_y;

   // branch decision
   logic rs_eq_rt;
   if (BRANCH_VIA_ALU) begin : g_eq_alu
      assign rs_eq_rt = alu_zero;
   end else begin : g_eq_cmp
      assign rs_eq_rt = (rs_val == rt_val);
   end

   assign pc_plus4  = pc_q + 32'd4;
   assign pc_branch = pc_plus4 + {imm_ext[29:0], 2'b00};
   assign pc_next   = (ctrl.branch && rs_eq_rt) ? pc_branch : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   assign pc_out = pc_q;

   logic unused_bits;
   assign unused_bits = ^{load_addr, peek_addr, alu_carry};
endmodule

// File: rtl/scp_checker.sv
module scp_checker
   import scp_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic [31:0] instr,
   input logic [31:0] rs_val,
   input logic [31:0] rt_val,
   input logic        rf_we,
   input logic        dmem_we,
   input logic        alu_carry
);
   logic [5:0]  op;
   logic [31:0] off4;
   assign op   = instr[31:26];
   assign off4 = {{14{instr[15]}}, instr[15:0], 2'b00};

   a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
      (op != OP_BEQ) |=> (pc == $past(pc) + 32'd4));

   a_r5_beq_taken: assert property (@(posedge clk) disable iff (rst)
      (op == OP_BEQ && rs_val == rt_val) |=> (pc == $past(pc) + 32'd4 + $past(off4)));

   a_r5_beq_not_taken: assert property (@(posedge clk) disable iff (rst)
      (op == OP_BEQ && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

   a_r5_equal_sub_carries: assert property (@(posedge clk) disable iff (rst)
      (op == OP_BEQ && rs_val == rt_val) |-> alu_carry);

   a_r6_zero_reg: assert property (@(posedge clk) disable iff (rst)
      (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

   a_r4_store_only_sw: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (op == OP_SW));

   a_r7_write_only_wb_ops: assert property (@(posedge clk) disable iff (rst)
      rf_we |-> (op == OP_REG || op == OP_LDI || op == OP_LW));
endmodule

bind cpu_single_cycle scp_checker u_scp_checker (
   .clk       (clk),
   .rst       (rst),
   .pc        (pc_q),
   .instr     (instr),
   .rs_val    (rs_val),
   .rt_val    (rt_val),
   .rf_we     (rf_we),
   .dmem_we   (dmem_we),
   .alu_carry (alu_carry)
);

// File: tb/test_cpu_single_cycle.sv
module test_cpu_single_cycle;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          load_we = 1'b0;
   logic          load_to_imem = 1'b0;
   logic [PW-1:0] load_addr = '0;
   logic [31:0]   load_data = '0;
   logic [4:0]    peek_reg = '0;
   logic [31:0]   peek_reg_data;
   logic [PW-1:0] peek_addr = '0;
   logic [31:0]   peek_mem_data;
   logic [31:0]   pc_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [31:0] m_reg [32];
   logic [31:0] m_mem [64];
   bit          m_wr  [64];

   always #10 clk = ~clk;

   cpu_single_cycle i_cpu_single_cycle (
      .clk(clk), .rst(rst), .load_we(load_we), .load_to_imem(load_to_imem),
      .load_addr(load_addr), .load_data(load_data), .peek_reg(peek_reg),
      .peek_reg_data(peek_reg_data), .peek_addr(peek_addr),
      .peek_mem_data(peek_mem_data), .pc_out(pc_out)
   );

   function automatic logic [31:0] enc_r(int rd, int rs, int rt, int fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
   endfunction

   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   function automatic logic [31:0] sx(int imm);
      logic [15:0] h = 16'(imm);
      return {{16{h[15]}}, h};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic put(input bit to_imem, input int addr, input logic [31:0] data);
      @(negedge clk);
      load_we = 1'b1; load_to_imem = to_imem;
      load_addr = PW'(addr); load_data = data;
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic reg_val(input int r, output logic [31:0] v);
      @(negedge clk);
      peek_reg = 5'(r);
      #1 v = peek_reg_data;
   endtask

   task automatic mem_val(input int a, output logic [31:0] v);
      @(negedge clk);
      peek_addr = PW'(a);
      #1 v = peek_mem_data;
   endtask

   task automatic run(input int cycles);
      @(negedge clk);
      rst = 1'b0;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4711));

      // ---------- directed program ----------
      hold_reset();
      put(0, 10, 32'hCAFE0001);                   // R9: preload data word
      put(1, 0,  enc_i(13, 0, 1, 10));            // LDI R1,10
      put(1, 1,  enc_i(13, 0, 2, -3));            // LDI R2,-3
      put(1, 2,  enc_r(3, 1, 2, 32));             // ADD R3
      put(1, 3,  enc_r(4, 2, 1, 34));             // SUB R4
      put(1, 4,  enc_i(43, 0, 3, 8));             // SW R3 -> word 2
      put(1, 5,  enc_i(35, 0, 5, 8));             // LW R5
      put(1, 6,  enc_i(35, 1, 6, -2));            // LW R6 via negative offset
      put(1, 7,  enc_i(13, 0, 0, 5));             // write to R0
      put(1, 8,  enc_i(63, 0, 12, 5));            // unknown opcode
      put(1, 9,  enc_r(7, 1, 2, 0));              // funct 0: no write
      put(1, 10, enc_i(4, 1, 2, 5));              // BEQ not taken
      put(1, 11, enc_i(13, 0, 8, 1));
      put(1, 12, enc_i(4, 3, 5, 1));              // BEQ taken, skips 13
      put(1, 13, enc_i(13, 0, 9, 99));
      put(1, 14, enc_i(13, 0, 10, 2));
      put(1, 15, enc_i(13, 0, 11, 20));
      put(1, 16, enc_i(43, 11, 4, -4));           // SW R4 -> word 4
      put(1, 17, enc_i(35, 0, 13, 40));           // LW preloaded word 10
      put(1, 18, enc_i(4, 0, 0, -1));             // park
      mem_val(10, v); chk("R9 preload/peek data word", v, 32'hCAFE0001);
      reg_val(1, v);  chk("R1 register clear in reset", v, 32'd0);
      chk("R1 pc in reset", pc_out, 32'd0);
      run(40);
      reg_val(1, v);  chk("R3 ldi positive", v, 32'd10);
      reg_val(2, v);  chk("R3 ldi negative", v, 32'hFFFF_FFFD);
      reg_val(3, v);  chk("R2 add", v, 32'd7);
      reg_val(4, v);  chk("R2 sub", v, 32'hFFFF_FFF3);
      reg_val(5, v);  chk("R4 load after store", v, 32'd7);
      reg_val(6, v);  chk("R4 load negative offset", v, 32'd7);
      reg_val(0, v);  chk("R6 r0 stays zero", v, 32'd0);
      reg_val(12, v); chk("R7 unknown opcode no write", v, 32'd0);
      reg_val(7, v);  chk("R2 unknown funct no write", v, 32'd0);
      reg_val(8, v);  chk("R5 not-taken falls through", v, 32'd1);
      reg_val(9, v);  chk("R5 taken skips", v, 32'd0);
      reg_val(10, v); chk("R5 taken target executes", v, 32'd2);
      reg_val(13, v); chk("R4 load preloaded word", v, 32'hCAFE0001);
      mem_val(2, v);  chk("R4 store word", v, 32'd7);
      mem_val(4, v);  chk("R4 store negative offset", v, 32'hFFFF_FFF3);
      chk("R8 parked pc", pc_out, 32'd72);

      // ---------- reset clears ----------
      hold_reset();
      chk("R1 pc after reset", pc_out, 32'd0);
      for (int r = 0; r < 32; r++) begin
         reg_val(r, v); chk($sformatf("R1 reg %0d cleared", r), v, 32'd0);
      end
      mem_val(2, v); chk("R1 data store kept", v, 32'd7);

      // ---------- backward branch loop ----------
      put(1, 0, enc_i(13, 0, 1, 0));
      put(1, 1, enc_i(13, 0, 2, 1));
      put(1, 2, enc_i(13, 0, 3, 5));
      put(1, 3, enc_r(1, 1, 2, 32));
      put(1, 4, enc_i(4, 1, 3, 1));
      put(1, 5, enc_i(4, 0, 0, -3));
      put(1, 6, enc_i(4, 0, 0, -1));
      run(40);
      reg_val(1, v); chk("R5 backward loop count", v, 32'd5);
      chk("R8 loop parked pc", pc_out, 32'd24);

      // ---------- constrained random stream ----------
      hold_reset();
      for (int r = 0; r < 32; r++) m_reg[r] = '0;
      for (int k = 0; k < 64; k++) m_wr[k] = 0;
      begin
         int idx = 0;
         for (int r = 1; r < 32; r++) begin
            int imm = int'($urandom % 65536);
            put(1, idx, enc_i(13, 0, r, imm));
            m_reg[r] = sx(imm);
            idx++;
         end
         for (int n = 0; n < 50; n++) begin
            int kind = int'($urandom % 5);
            int a = int'($urandom % 32);
            int b = int'($urandom % 32);
            int c = int'($urandom % 32);
            int imm = int'($urandom % 65536);
            int k = int'($urandom % 64);
            logic [31:0] res;
            if (kind == 4 && !m_wr[k]) kind = 3;
            case (kind)
               0: begin put(1, idx, enc_r(c, a, b, 32)); res = m_reg[a] + m_reg[b];
                        if (c != 0) m_reg[c] = res; end
               1: begin put(1, idx, enc_r(c, a, b, 34)); res = m_reg[a] - m_reg[b];
                        if (c != 0) m_reg[c] = res; end
               2: begin put(1, idx, enc_i(13, a, b, imm)); res = m_reg[a] + sx(imm);
                        if (b != 0) m_reg[b] = res; end
               3: begin put(1, idx, enc_i(43, 0, b, 4 * k)); m_mem[k] = m_reg[b];
                        m_wr[k] = 1; end
               default: begin put(1, idx, enc_i(35, 0, b, 4 * k));
                        if (b != 0) m_reg[b] = m_mem[k]; end
            endcase
            idx++;
         end
         put(1, idx, enc_i(4, 0, 0, -1));
         run(100);
         chk("R8 random parked pc", pc_out, 32'(idx * 4));
      end
      for (int r = 0; r < 32; r++) begin
         reg_val(r, v); chk($sformatf("R2 random reg %0d", r), v, m_reg[r]);
      end
      for (int k = 0; k < 64; k++) begin
         if (m_wr[k]) begin
            mem_val(k, v); chk($sformatf("R4 random word %0d", k), v, m_mem[k]);
         end
      end

      done = 1;
      summary();
      $finish;
   end
endmodule